// File: doc/BRIEF.md
# Three-Wire Synthesizer Loader

This block programs an external frequency synthesizer with two frequency words over three wires: serial data, serial clock and a latch strobe. When the unit moves from its off state to its on state, and a configuration input allows it, the block first turns on the synthesizer oscillator. It then shifts out word A and pulses the latch, waits, shifts out word B and pulses the latch again. Both words are parallel inputs of up to 24 bits. They are sent most significant bit first, so any padding must sit in the high-order bits and only the trailing bits reach the synthesizer.

All serial timing is counted in timebase ticks. One clock enable, `tick`, marks a tick. On the 13th bit of each word the clock-low phase is stretched by a pause, and the same pause is added to the gap before the second word. The pause length follows the selected reception bit rate.

Top module: `synth_loader`

## Requirements
- R1: A transfer starts on the clock edge where `power_on` is high after being low on the previous edge, provided `feat_en` is high and no transfer is running. Without `feat_en` a rising `power_on` starts nothing.
- R2: Both words are captured when the transfer starts. Word A is sent first, then word B. Each word sends all 24 bits, bit 23 first and bit 0 last.
- R3: Each bit spends one tick with `ser_clk` low and then one tick with `ser_clk` high. `ser_data` holds the bit through both phases and changes only when `ser_clk` falls.
- R4: The 13th bit sent in each word (word bit 11) keeps `ser_clk` low for 1 + P ticks, where P is the pause.
- R5: P is taken from `rate_sel` when the transfer starts: 2'b00 (512 bit/s) gives 119, 2'b01 (1200 bit/s) gives 33, and 2'b10 (2400 bit/s) or 2'b11 gives 1.
- R6: After the 24th clock-high phase of a word, `latch_en` is high for exactly one tick. During that tick `ser_clk` and `ser_data` are low.
- R7: After the first latch pulse, the line stays idle for 1 + P ticks before the first bit of word B.
- R8: `osc_en` rises on the start edge. One lead tick with the lines idle follows before the first bit. `osc_en` stays high through the transfer and afterwards, and drops only while no transfer runs and `power_on` is low.
- R9: `busy` is high from the start edge until the second latch pulse ends. A `power_on` rise while `busy` is high is ignored.
- R10: `done` is high for one clock cycle, on the edge where the second latch pulse ends. Serial outputs change only on edges where `tick` is high, except at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase tick enable |
| power_on | input | 1 | Unit on (1) or off (0) |
| feat_en | input | 1 | Allows a transfer on power-up |
| rate_sel | input | 2 | Reception bit-rate select |
| word_a | input | 24 | First frequency word |
| word_b | input | 24 | Second frequency word |
| ser_data | output | 1 | Serial data to synthesizer |
| ser_clk | output | 1 | Serial clock, idles low |
| latch_en | output | 1 | Latch strobe, idles low |
| osc_en | output | 1 | Synthesizer oscillator enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Every output is registered. A start edge shows on `osc_en` and `busy` one clock later, and each tick edge moves the serial lines one clock later. The bench's reference model holds a queue of line segments, each with its length in ticks. The model updates on the same rising edge as the design, and the outputs are compared at every falling edge, so the checks see each value in the cycle it is due. Tick spacings of one and three clocks and all four rate codes check that the stretched bit, the gap and the `done` pulse land on the right edge.

// File: rtl/synl_pkg.sv
package synl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_LATCH,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/synl_pause.sv
module synl_pause #(
    parameter int PAUSE_SLOW = 119,
    parameter int PAUSE_MID  = 33,
    parameter int PAUSE_FAST = 1,
    parameter int CNT_W      = $clog2(PAUSE_SLOW + 2)
) (
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] pause
);

    always_comb begin
        case (rate_sel)
            2'b00:   pause = CNT_W'(PAUSE_SLOW);
            2'b01:   pause = CNT_W'(PAUSE_MID);
            default: pause = CNT_W'(PAUSE_FAST);
        endcase
    end

endmodule

// File: rtl/synl_trigger.sv
module synl_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic power_on,
    input  logic feat_en,
    input  logic busy,
    output logic start
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = power_on;
        start  = power_on && !prev_q && feat_en && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R1

endmodule

// File: rtl/synl_seq.sv
module synl_seq
    import synl_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CNT_W       = 7,
    parameter int STRETCH_IDX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              power_on,
    input  logic [CNT_W-1:0]  pause,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              latch_en,
    output logic              osc_en,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] STRETCH_POS = IDX_W'(STRETCH_IDX);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  sent;
        logic              second;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  pause;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] hold_b;
        logic              sdata;
        logic              sclk;
        logic              latch;
        logic              osc;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        low_len = (r_q.sent == STRETCH_POS) ? CNT_W'(r_q.pause + 1'b1) : CNT_W'(1);
        cnt_inc = CNT_W'(r_q.cnt + 1'b1);
        r_d      = r_q;
        r_d.done = 1'b0;

        if (start) begin
            r_d.state  = ST_LEAD;
            r_d.shreg  = word_a;
            r_d.hold_b = word_b;
            r_d.pause  = pause;
            r_d.second = 1'b0;
            r_d.osc    = 1'b1;
            r_d.sdata  = 1'b0;
            r_d.sclk   = 1'b0;
            r_d.latch  = 1'b0;
        end else if (r_q.state == ST_IDLE) begin
            if (!power_on) r_d.osc = 1'b0;
        end else if (tick) begin
            case (r_q.state)
                ST_LEAD: begin
                    r_d.state = ST_LOW;
                    r_d.sent  = '0;
                    r_d.cnt   = '0;
                    r_d.sdata = r_q.shreg[WORD_W-1];
                end
                ST_LOW: begin
                    if (cnt_inc >= low_len) begin
                        r_d.state = ST_HIGH;
                        r_d.sclk  = 1'b1;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
                ST_HIGH: begin
                    r_d.sclk = 1'b0;
                    if (r_q.sent == LAST_IDX) begin
                        r_d.state = ST_LATCH;
                        r_d.latch = 1'b1;
                        r_d.sdata = 1'b0;
                    end else begin
                        r_d.state = ST_LOW;
                        r_d.sent  = r_q.sent + 1'b1;
                        r_d.shreg = {r_q.shreg[WORD_W-2:0], 1'b0};
                        r_d.sdata = r_q.shreg[WORD_W-2];
                    end
                end
                ST_LATCH: begin
                    r_d.latch = 1'b0;
                    if (!r_q.second) begin
                        r_d.state = ST_GAP;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt_inc >= CNT_W'(r_q.pause + 1'b1)) begin
                        r_d.state  = ST_LOW;
                        r_d.second = 1'b1;
                        r_d.shreg  = r_q.hold_b;
                        r_d.sdata  = r_q.hold_b[WORD_W-1];
                        r_d.sent   = '0;
                        r_d.cnt    = '0;
                    end else begin
                        r_d.cnt = cnt_inc;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ser_data = r_q.sdata;
    assign ser_clk  = r_q.sclk;
    assign latch_en = r_q.latch;
    assign osc_en   = r_q.osc;
    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;

    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> !ser_clk); // R6

    AST_DATA_STEADY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data)); // R3

    AST_OSC_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> osc_en); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && busy) |=> ($stable(ser_clk) && $stable(latch_en))); // R10

endmodule

// File: rtl/synth_loader.sv
module synth_loader #(
    parameter int WORD_W      = 24,
    parameter int STRETCH_IDX = 12,
    parameter int PAUSE_SLOW  = 119,
    parameter int PAUSE_MID   = 33,
    parameter int PAUSE_FAST  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              power_on,
    input  logic              feat_en,
    input  logic [1:0]        rate_sel,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              latch_en,
    output logic              osc_en,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(PAUSE_SLOW + 2);

    logic             start;
    logic [CNT_W-1:0] pause;

    synl_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .power_on (power_on),
        .feat_en  (feat_en),
        .busy     (busy),
        .start    (start)
    );

    synl_pause #(
        .PAUSE_SLOW (PAUSE_SLOW),
        .PAUSE_MID  (PAUSE_MID),
        .PAUSE_FAST (PAUSE_FAST),
        .CNT_W      (CNT_W)
    ) u_pause (
        .rate_sel (rate_sel),
        .pause    (pause)
    );

    synl_seq #(
        .WORD_W      (WORD_W),
        .CNT_W       (CNT_W),
        .STRETCH_IDX (STRETCH_IDX)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .power_on (power_on),
        .pause    (pause),
        .word_a   (word_a),
        .word_b   (word_b),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .latch_en (latch_en),
        .osc_en   (osc_en),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: tb/sim_synth_loader.sv
`timescale 1ns/1ps
module sim_synth_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        power_on = 1'b0;
    logic        feat_en = 1'b0;
    logic [1:0]  rate_sel = 2'b10;
    logic [23:0] word_a = '0;
    logic [23:0] word_b = '0;
    logic ser_data, ser_clk, latch_en, osc_en, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_period = 1;
    int tick_ctr = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    synth_loader u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .power_on(power_on),
        .feat_en(feat_en), .rate_sel(rate_sel), .word_a(word_a), .word_b(word_b),
        .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en),
        .osc_en(osc_en), .busy(busy), .done(done)
    );

    // reference model: queue of line segments with tick lengths
    int q_d[$];
    int q_c[$];
    int q_l[$];
    int q_n[$];
    bit m_prev = 1'b0;
    bit e_data = 0, e_clk = 0, e_latch = 0, e_osc = 0, e_busy = 0, e_done = 0;

    function automatic int pause_of(input logic [1:0] r);
        if (r == 2'b00) return 119;
        if (r == 2'b01) return 33;
        return 1;
    endfunction

    function automatic void push_seg(input int d, input int c, input int l, input int n);
        q_d.push_back(d); q_c.push_back(c); q_l.push_back(l); q_n.push_back(n);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_d.delete(); q_c.delete(); q_l.delete(); q_n.delete();
            m_prev = 0; e_osc = 0; e_done = 0;
        end else begin
            bit pre_empty;
            bit trig;
            pre_empty = (q_n.size() == 0);
            trig = power_on && !m_prev && feat_en && pre_empty;
            m_prev = power_on;
            e_done = 0;
            if (!pre_empty && tick) begin
                q_n[0] = q_n[0] - 1;
                if (q_n[0] == 0) begin
                    void'(q_d.pop_front()); void'(q_c.pop_front());
                    void'(q_l.pop_front()); void'(q_n.pop_front());
                    if (q_n.size() == 0) e_done = 1;
                end
            end
            if (trig) begin
                int p;
                p = pause_of(rate_sel);
                push_seg(0, 0, 0, 1);
                for (int w = 0; w < 2; w++) begin
                    logic [23:0] wd;
                    wd = (w == 0) ? word_a : word_b;
                    if (w == 1) push_seg(0, 0, 0, 1 + p);
                    for (int b = 0; b < 24; b++) begin
                        push_seg(int'(wd[23-b]), 0, 0, (b == 12) ? 1 + p : 1);
                        push_seg(int'(wd[23-b]), 1, 0, 1);
                    end
                    push_seg(0, 0, 1, 1);
                end
                e_osc = 1;
            end else if (pre_empty && !power_on) begin
                e_osc = 0;
            end
        end
        if (q_n.size() > 0) begin
            e_data = q_d[0][0]; e_clk = q_c[0][0]; e_latch = q_l[0][0]; e_busy = 1;
        end else begin
            e_data = 0; e_clk = 0; e_latch = 0; e_busy = 0;
        end
    end

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, nm, cycles, act, exp);
        end
    endtask

    // compare all outputs away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!finished) begin
            chk("R2/R3", "ser_data", ser_data, e_data);
            chk("R3/R4", "ser_clk", ser_clk, e_clk);
            chk("R6", "latch_en", latch_en, e_latch);
            chk("R8", "osc_en", osc_en, e_osc);
            chk("R9", "busy", busy, e_busy);
            chk("R10", "done", done, e_done);
        end
        // timebase tick generation
        if (tick_ctr + 1 >= tick_period) begin tick_ctr = 0; tick <= 1'b1; end
        else begin tick_ctr++; tick <= 1'b0; end
    end

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while ((busy || e_busy) && guard < 5000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_xfer(input logic [1:0] r, input int tp, input logic [23:0] a, input logic [23:0] b);
        @(negedge clk);
        tick_period = tp; rate_sel = r; word_a = a; word_b = b; feat_en = 1'b1;
        power_on = 1'b0;
        repeat (2) @(negedge clk);
        power_on = 1'b1;      // R1 rising edge
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8 R9 reset state
        chk("R8", "reset osc_en", osc_en, 1'b0);
        chk("R9", "reset busy", busy, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_xfer(2'b10, 1, 24'hA5C3_0F, 24'h3C_96E1);   // R2 R3 R6 fast rate
        run_xfer(2'b01, 3, 24'hFFF_000, 24'h000_FFF);   // R4 R5 R7 mid rate, sparse tick
        run_xfer(2'b00, 1, 24'h123456, 24'hFEDCBA);     // R5 slow rate
        run_xfer(2'b11, 2, 24'h800001, 24'h7FFFFE);     // R5 code 11

        // R1: feature disabled, rise of power starts nothing
        @(negedge clk); power_on = 1'b0; feat_en = 1'b0;
        repeat (3) @(negedge clk);
        power_on = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1", "no start without feat_en", busy, 1'b0);

        // R9: retrigger while busy is ignored
        feat_en = 1'b1; power_on = 1'b0; tick_period = 1; rate_sel = 2'b01;
        word_a = 24'h0F0F0F; word_b = 24'hF0F0F0;
        repeat (3) @(negedge clk);
        power_on = 1'b1;
        repeat (30) @(negedge clk);
        power_on = 1'b0;
        repeat (4) @(negedge clk);
        word_a = 24'hFFFFFF;
        power_on = 1'b1;
        wait_idle();

        // R8: oscillator drops once idle and off
        power_on = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8", "osc_en off when idle", osc_en, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired: actual hang expected finish");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule